// File: doc/BRIEF.md
# Command/Address Parity Checking Register

This block sits between a host memory controller and the DRAM devices of a registered module. Each clock cycle it may receive a command/address word, a chip-select qualifier, a command-type flag and a parity bit. It registers the word toward the DRAM side. When a chip select is asserted, the block checks even parity over the word and the parity bit. It then forwards the word or drops it, depending on the result and on a parity-enable bit taken from a configuration control word.

A cycle can carry one of two kinds of traffic, chosen by a flag. A normal command is forwarded on the DRAM-side command strobe. A control-word write is forwarded on a separate control-word strobe. Both kinds get the same parity check. When a checked cycle fails, the block pulls an active-low alert flag low for a fixed number of cycles. That flag is meant to drive an open-drain pin outside the block.

The DRAM side cannot stall the bus, so the block has no back-pressure. There is no ready signal, and every selected cycle is accepted in the cycle it is presented. The two output strobes act as valid qualifiers for the registered word. They are high for exactly one cycle per forwarded transfer.

Top module: `ca_parity_reg`

## Requirements
- R1: While reset is held and in the first cycle after it, `alert_n` is 1, `cmd_vld` and `cw_vld` are 0, and `ca_out` is all zeros.
- R2: A selected cycle has a parity error exactly when the XOR of every bit of `ca_in` together with `par_in` is 1 (even parity).
- R3: A selected normal command (`cw_wr`=0) with no parity error appears one cycle later: `cmd_vld`=1 for that cycle and `ca_out` equal to the sampled `ca_in`.
- R4: With `chk_en`=1, a selected cycle that has a parity error is dropped. In the next cycle both `cmd_vld` and `cw_vld` are 0, and `ca_out` keeps its previous value.
- R5: With `chk_en`=0, every selected cycle is forwarded whatever its parity, and it never starts an alert pulse.
- R6: A selected cycle with `cw_wr`=1 is a control-word write. It is forwarded on `cw_vld` and never on `cmd_vld`, and it is parity checked in the same way as a command. The two strobes are never high together.
- R7: A cycle with `sel_n`=1 is neither checked nor forwarded. In the next cycle both strobes are 0 and `ca_out` keeps its previous value.
- R8: A blocked cycle drives `alert_n` to 0 from the cycle after it, which is the cycle where its forwarded word would have appeared. `alert_n` stays 0 for exactly ALERT_LEN cycles and then returns to 1.
- R9: A further blocked cycle during an alert pulse restarts the pulse. `alert_n` then stays 0 until ALERT_LEN cycles after the latest blocked cycle's word slot.
- R10: `chk_en` is sampled in the same cycle as the command it governs. Changing it from one cycle to the next changes the handling of each cycle on its own terms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low chip-select qualifier; the cycle is ignored when high |
| ca_in | input | CA_W | Qualified command/address word from the host |
| par_in | input | 1 | Even-parity bit sent by the host with `ca_in` |
| cw_wr | input | 1 | 1 marks the cycle as a control-word write |
| chk_en | input | 1 | Parity-check enable from the configuration control word |
| ca_out | output | CA_W | Registered command/address word toward the DRAM side |
| cmd_vld | output | 1 | One-cycle strobe: `ca_out` holds a forwarded command |
| cw_vld | output | 1 | One-cycle strobe: `ca_out` holds a forwarded control-word write |
| alert_n | output | 1 | Active-low parity alert, to drive an open-drain pin |

## Verification
The bench targets back-to-back bad-parity cycles. A design that counted pulses instead of restarting them would release `alert_n` early. It also drops the enable bit in the middle of a run of bad-parity cycles. A design that registered `chk_en` one cycle late would block a command that should pass, or pass one that should be blocked. Deselected cycles with bad parity are included. A design that checked before qualifying would raise a false alert or disturb `ca_out`. Control-word writes with bad parity are included too, to catch a design that routed them to the command strobe or skipped their check.

// File: rtl/ca_par_pkg.sv
package ca_par_pkg;

  typedef enum logic [1:0] {
    XFER_NONE = 2'd0,
    XFER_CMD  = 2'd1,
    XFER_CW   = 2'd2
  } xfer_kind_t;

endpackage

// File: rtl/ca_par_check.sv
module ca_par_check #(
  parameter int CA_W   = 28,
  parameter int LANE_W = 8
) (
  input  logic [CA_W-1:0] ca,
  input  logic            par,
  output logic            err
);
  localparam int LANES = (CA_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] ca_pad;
  logic [LANES-1:0] lane_par;

  assign ca_pad = {{(PAD_W-CA_W){1'b0}}, ca};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_par[g] = ^ca_pad[g*LANE_W +: LANE_W];
  end

  // R2: even parity over the word plus the parity bit
  assign err = (^lane_par) ^ par;

endmodule

// File: rtl/ca_fwd_stage.sv
module ca_fwd_stage
  import ca_par_pkg::*;
#(
  parameter int CA_W = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  xfer_kind_t      kind,
  input  logic [CA_W-1:0] ca_in,
  output logic [CA_W-1:0] ca_out,
  output logic            cmd_vld,
  output logic            cw_vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca_out  <= '0;
      cmd_vld <= 1'b0;
      cw_vld  <= 1'b0;
    end else begin
      cmd_vld <= (kind == XFER_CMD);
      cw_vld  <= (kind == XFER_CW);
      if (kind != XFER_NONE) ca_out <= ca_in;
    end
  end

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_vld && cw_vld));

  a_r4_hold_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == XFER_NONE) |=> ($stable(ca_out) && !cmd_vld && !cw_vld));

endmodule

// File: rtl/ca_alert_pulse.sv
module ca_alert_pulse #(
  parameter int ALERT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic alert_n
);
  localparam int CNT_W = $clog2(ALERT_LEN + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                remain <= '0;
    else if (trig)             remain <= CNT_W'(ALERT_LEN);
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  assign alert_n = (remain == '0);

  a_r8_starts: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !alert_n);

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && alert_n) |=> alert_n);

endmodule

// File: rtl/ca_parity_reg.sv
module ca_parity_reg
  import ca_par_pkg::*;
#(
  parameter int CA_W      = 28,
  parameter int LANE_W    = 8,
  parameter int ALERT_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic [CA_W-1:0] ca_in,
  input  logic            par_in,
  input  logic            cw_wr,
  input  logic            chk_en,
  output logic [CA_W-1:0] ca_out,
  output logic            cmd_vld,
  output logic            cw_vld,
  output logic            alert_n
);
  logic       par_err;
  logic       block;
  xfer_kind_t kind;

  ca_par_check #(.CA_W(CA_W), .LANE_W(LANE_W)) u_check (
    .ca  (ca_in),
    .par (par_in),
    .err (par_err)
  );

  // R5 / R10: enable taken from the same cycle as the command
  assign block = !sel_n && chk_en && par_err;

  always_comb begin
    if (sel_n || block) kind = XFER_NONE;
    else if (cw_wr)     kind = XFER_CW;
    else                kind = XFER_CMD;
  end

  ca_fwd_stage #(.CA_W(CA_W)) u_fwd (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .ca_in   (ca_in),
    .ca_out  (ca_out),
    .cmd_vld (cmd_vld),
    .cw_vld  (cw_vld)
  );

  ca_alert_pulse #(.ALERT_LEN(ALERT_LEN)) u_alert (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (block),
    .alert_n (alert_n)
  );

  a_r3_cmd_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !cw_wr && !(chk_en && par_err)) |=> (cmd_vld && ca_out == $past(ca_in)));

  a_r7_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (!cmd_vld && !cw_vld));

  a_r5_no_alert_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en && alert_n) |=> alert_n);

endmodule

// File: tb/ca_parity_reg_bench.sv
`timescale 1ns/1ps
module ca_parity_reg_bench;
  localparam int CA_W = 28;
  localparam int ALEN = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sel_n = 1'b1;
  logic [CA_W-1:0] ca_in = '0;
  logic            par_in = 1'b0;
  logic            cw_wr = 1'b0;
  logic            chk_en = 1'b1;
  logic [CA_W-1:0] ca_out;
  logic            cmd_vld, cw_vld, alert_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [CA_W-1:0] m_ca = '0;
  bit m_cmd = 0, m_cw = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  ca_parity_reg #(.CA_W(CA_W), .ALERT_LEN(ALEN)) u_ca_parity_reg (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ca_in(ca_in), .par_in(par_in),
    .cw_wr(cw_wr), .chk_en(chk_en), .ca_out(ca_out), .cmd_vld(cmd_vld),
    .cw_vld(cw_vld), .alert_n(alert_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, 64'(ca_out), 64'(m_ca), "ca_out");
    chk(tag, 64'(cmd_vld), 64'(m_cmd), "cmd_vld");
    chk(tag, 64'(cw_vld), 64'(m_cw), "cw_vld");
    chk(tag, 64'(alert_n), 64'(m_cnt == 0), "alert_n");
  endtask

  // drive one cycle at a negedge, advance the model, compare at next negedge
  task automatic step(input bit s_n, input logic [CA_W-1:0] ca, input bit bad,
                      input bit en, input bit cw, input string tag);
    bit perr;
    sel_n = s_n; ca_in = ca; par_in = (^ca) ^ bad; chk_en = en; cw_wr = cw;
    perr = bad;
    if (!s_n && !(en && perr)) begin
      m_ca = ca; m_cmd = !cw; m_cw = cw;
      if (m_cnt > 0) m_cnt--;
    end else begin
      m_cmd = 0; m_cw = 0;
      if (!s_n && en && perr) m_cnt = ALEN;
      else if (m_cnt > 0) m_cnt--;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    step(0, 28'h0ABCDEF, 0, 1, 0, "R3 good command");
    step(0, 28'h1234567, 0, 1, 0, "R3 second command");
    step(0, 28'hFFFFFFF, 1, 1, 0, "R2 R4 bad parity blocked");
    for (int i = 0; i < ALEN + 1; i++) step(1, 28'h0, 0, 1, 0, "R8 pulse length");
    step(0, 28'h0000001, 1, 1, 0, "R8 single-bit error");
    step(0, 28'h0000003, 1, 1, 0, "R9 retrigger");
    step(0, 28'h0000007, 0, 1, 0, "R9 good during pulse");
    for (int i = 0; i < ALEN; i++) step(1, 28'h0, 0, 1, 0, "R9 pulse tail");
    step(0, 28'h5555555, 1, 0, 0, "R5 disabled bad forwarded");
    step(0, 28'h2AAAAAA, 1, 0, 1, "R5 disabled bad cw forwarded");
    step(0, 28'h0F0F0F0, 0, 1, 1, "R6 good control word");
    step(0, 28'h0F0F0F1, 1, 1, 1, "R6 bad control word blocked");
    step(1, 28'h7777777, 1, 1, 0, "R7 deselected bad parity");
    step(1, 28'h1111111, 0, 1, 1, "R7 deselected cw");
    for (int i = 0; i < ALEN; i++) step(1, 28'h0, 0, 1, 0, "R7 idle");
    step(0, 28'h0C0FFEE, 1, 1, 0, "R10 enabled blocks");
    step(0, 28'h0BEEF00, 1, 0, 0, "R10 disabled passes");
    step(0, 28'h0DEAD01, 1, 1, 0, "R10 enabled again");
    for (int i = 0; i < 400; i++) begin
      automatic logic [31:0] r = $urandom;
      step(r[0] & r[1], CA_W'($urandom), r[2] & r[3], r[4] | r[5], r[6],
           "R2 random traffic");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule